// File: doc/BRIEF.md
# Framed SPI Master Controller

This block is an SPI bus master that software drives through a small word-addressed register file. Bytes to send are pushed into a transmit FIFO. Every byte shifted out brings one byte back, and that byte lands in a receive FIFO that software drains through a read-to-pop data port. A configuration word sets clock polarity, clock phase and bit order, and turns on frame mode. A clock word holds a 16-bit divider whose two bytes are stored in separate fields of that word.

In frame mode the select line falls when the first byte of a frame starts. It then stays low across any number of back-to-back bytes. It rises only after the byte written directly after an end-of-frame command has been fully shifted. With frame mode off, the select line rises after every byte.

A sticky transmit-empty flag, cleared by writing a one to it, combines with a mask bit to form the interrupt. When the receive FIFO is full, the shifter waits before starting another byte, so no data is ever lost.

Top module: `spi_frame_master`

Register map (word addresses):
- 0: configuration word. Bit 13 is clock polarity, bit 12 is clock phase, bit 28 selects LSB-first and bit 11 selects frame mode. The other bits are stored and read back.
- 1: clock word. The divider low byte is in bits 23:16 and the high byte in bits 15:8. Bits 31:24 are kept for read-back.
- 2: command (write only). Bit 0 flushes RX, bit 1 flushes TX, bit 2 enables TX, bit 3 disables TX, bit 4 enables RX, bit 5 disables RX.
- 3: TX data.
- 4: TX command. Bit 0 tags the next TX data write as end-of-frame.
- 5: TX status. Bit 0 is EMPTY; writing a one to it clears it.
- 6: TX interrupt mask. Bit 0 enables the interrupt.
- 7: RX count.
- 8: RX data. A read pops one byte.
- 9: TX size. Bits 10:0 hold the capacity divided by 4.
- 10: RX size. Same encoding as TX size.

## Requirements
- R1: After reset, the select line is high, SCK is low, irq is low and the RX count reads 0.
- R2: While the select line is high, SCK rests at the clock polarity bit (bit 13). With the phase bit (bit 12) at 0, data is sampled on the leading SCK edge and changed on the trailing edge. With the phase bit at 1, data is changed on the leading edge and sampled on the trailing edge. All four combinations move bytes correctly in both directions.
- R3: Configuration bit 28 at 1 shifts bit 0 first; at 0 it shifts bit 7 first. This applies to both MOSI and MISO.
- R4: Each SCK level lasts exactly divider+1 clock cycles. The divider is {clock word bits 15:8, bits 23:16}, and the whole clock word reads back as written.
- R5: In frame mode (bit 11 = 1), the select line stays low across consecutive bytes. It rises exactly once, right after the byte written following a TX command write with bit 0 = 1.
- R6: With frame mode off, the select line rises after every byte.
- R7: Each byte received while RX is enabled enters the RX FIFO. The RX count reports the number of stored bytes, and each read of RX data returns the oldest byte and removes it. While RX is disabled, received bytes are dropped.
- R8: While RX is enabled and the RX FIFO is full, no new byte starts. Once a byte is popped, transmission resumes.
- R9: TX status bit 0 becomes 1 when the TX FIFO is empty and the shifter is idle. It stays 1 until software writes a one to it. irq is high exactly while both that status bit and mask bit 0 are set.
- R10: The TX and RX size registers return the FIFO depth divided by 4 in bits 10:0.
- R11: The command register flushes the RX count to 0 (bit 0) and discards pending TX bytes (bit 1). While TX is disabled, no byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| spi_miso | input | 1 | Serial data from the slave |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_ss_n | output | 1 | Active-low slave select |
| irq | output | 1 | Masked TX-empty interrupt |

## Verification
The bench builds the block with a FIFO depth of 4. At that depth four received bytes fill the RX FIFO, which brings the receive-full stall within reach of a short run. The depth also gives a size-register value of 1. Most traffic runs with a divider of 1, so all eight mode and bit-order combinations fit in few cycles. One transfer uses a divider of 256 to show that the high divider byte takes effect.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  localparam int unsigned DIVW = 16;
  localparam logic [3:0] A_SIC  = 4'd0;
  localparam logic [3:0] A_CLK  = 4'd1;
  localparam logic [3:0] A_CMD  = 4'd2;
  localparam logic [3:0] A_TXD  = 4'd3;
  localparam logic [3:0] A_TXC  = 4'd4;
  localparam logic [3:0] A_TXS  = 4'd5;
  localparam logic [3:0] A_TXM  = 4'd6;
  localparam logic [3:0] A_RXC  = 4'd7;
  localparam logic [3:0] A_RXD  = 4'd8;
  localparam logic [3:0] A_TXSZ = 4'd9;
  localparam logic [3:0] A_RXSZ = 4'd10;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_TAIL} eng_state_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb;
    logic use_eof;
  } spi_cfg_t;
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] cnt_n;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    cnt_n = count;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = bump(wp);
      if (do_pop)  rp_n = bump(rp);
      if (do_push && !do_pop) cnt_n = count + 1'b1;
      if (do_pop && !do_push) cnt_n = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp_n;
      rp    <= rp_n;
      count <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  assign dout = mem[rp];
endmodule

// File: rtl/spi_fm_regs.sv
module spi_fm_regs
  import spi_fm_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic [3:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output spi_cfg_t        cfg,
  output logic [DIVW-1:0] div,
  output logic            tx_en,
  output logic            rx_en,
  output logic            tx_push,
  output logic [DW:0]     tx_din,
  output logic            tx_flush,
  output logic            rx_flush,
  output logic            rx_pop,
  input  logic [CW-1:0]   rx_count,
  input  logic [CW-1:0]   tx_count,
  input  logic [DW-1:0]   rx_head,
  input  logic            busy,
  output logic            stat,
  output logic            stat_clr,
  output logic            irq
);
  logic [31:0] sic, clkw;
  logic        pend, mask;
  logic        txen_n, rxen_n, pend_n, stat_n;
  logic        we_sic, we_clk, we_cmd, we_txc, we_txm;
  logic        rx_empty, tx_empty;
  logic [10:0] size_f;

  assign size_f   = 11'(DEPTH / 4);
  assign rx_empty = (rx_count == '0);
  assign tx_empty = (tx_count == '0);

  assign we_sic   = wr && (addr == A_SIC);
  assign we_clk   = wr && (addr == A_CLK);
  assign we_cmd   = wr && (addr == A_CMD);
  assign we_txc   = wr && (addr == A_TXC);
  assign we_txm   = wr && (addr == A_TXM);
  assign stat_clr = wr && (addr == A_TXS) && wdata[0];
  assign tx_push  = wr && (addr == A_TXD) && (tx_count != CW'(DEPTH));
  assign tx_din   = {pend, wdata[DW-1:0]};
  assign rx_pop   = rd && (addr == A_RXD) && !rx_empty;
  assign rx_flush = we_cmd && wdata[0];
  assign tx_flush = we_cmd && wdata[1];

  always_comb begin
    txen_n = tx_en;
    rxen_n = rx_en;
    pend_n = pend;
    if (we_cmd) begin
      if (wdata[2]) txen_n = 1'b1;
      if (wdata[3]) txen_n = 1'b0;
      if (wdata[4]) rxen_n = 1'b1;
      if (wdata[5]) rxen_n = 1'b0;
      if (wdata[1]) pend_n = 1'b0;
    end
    if (we_txc)  pend_n = wdata[0];
    if (tx_push) pend_n = 1'b0;
    stat_n = (tx_empty && !busy) || (stat && !stat_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sic   <= '0;
      clkw  <= '0;
      tx_en <= 1'b0;
      rx_en <= 1'b0;
      pend  <= 1'b0;
      mask  <= 1'b0;
      stat  <= 1'b0;
    end else begin
      if (we_sic) sic  <= wdata;
      if (we_clk) clkw <= wdata;
      if (we_txm) mask <= wdata[0];
      tx_en <= txen_n;
      rx_en <= rxen_n;
      pend  <= pend_n;
      stat  <= stat_n;
    end
  end

  assign cfg.cpol    = sic[13];
  assign cfg.cpha    = sic[12];
  assign cfg.lsb     = sic[28];
  assign cfg.use_eof = sic[11];
  assign div         = {clkw[15:8], clkw[23:16]};
  assign irq         = stat && mask;

  always_comb begin
    rdata = '0;
    case (addr)
      A_SIC:  rdata = sic;
      A_CLK:  rdata = clkw;
      A_TXS:  rdata = {31'd0, stat};
      A_TXM:  rdata = {31'd0, mask};
      A_RXC:  rdata = 32'(rx_count);
      A_RXD:  rdata = rx_empty ? '0 : 32'(rx_head);
      A_TXSZ: rdata = {21'd0, size_f};
      A_RXSZ: rdata = {21'd0, size_f};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
  import spi_fm_pkg::*;
#(
  parameter int unsigned DW  = 8,
  localparam int unsigned BW = $clog2(DW),
  localparam int unsigned HW = $clog2(2 * DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  spi_cfg_t        cfg,
  input  logic [DIVW-1:0] div,
  input  logic            tx_en,
  input  logic            rx_en,
  input  logic            tx_valid,
  input  logic [DW-1:0]   tx_byte,
  input  logic            tx_eof,
  input  logic            rx_full,
  output logic            tx_pop,
  output logic            rx_push,
  output logic [DW-1:0]   rx_byte,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            ss_n,
  output logic            busy,
  output logic            byte_done
);
  eng_state_e      st, st_n;
  logic [DIVW-1:0] tmr, tmr_n;
  logic [HW-1:0]   hc, hc_n;
  logic [BW-1:0]   bi, bi_n, pos;
  logic [DW-1:0]   txb, txb_n, rxb, rxb_n;
  logic            eof_r, eof_n, sck_r, sck_n, ss_r, ss_nx;
  logic            expire, start, odd, sample_e, shift_e;

  assign expire   = (tmr == div);
  assign start    = tx_en && tx_valid && !(rx_en && rx_full);
  assign pos      = cfg.lsb ? bi : (BW'(DW - 1) - bi);
  assign odd      = hc[0];
  assign sample_e = cfg.cpha ? odd : !odd;
  assign shift_e  = cfg.cpha ? (!odd && (hc != '0)) : (odd && (hc != HW'(2 * DW - 1)));

  always_comb begin
    st_n      = st;
    tmr_n     = tmr;
    hc_n      = hc;
    bi_n      = bi;
    txb_n     = txb;
    rxb_n     = rxb;
    eof_n     = eof_r;
    sck_n     = sck_r;
    ss_nx     = ss_r;
    tx_pop    = 1'b0;
    rx_push   = 1'b0;
    byte_done = 1'b0;
    case (st)
      ENG_IDLE: begin
        if (start) begin
          tx_pop = 1'b1;
          txb_n  = tx_byte;
          eof_n  = tx_eof;
          ss_nx  = 1'b0;
          sck_n  = cfg.cpol;
          tmr_n  = '0;
          hc_n   = '0;
          bi_n   = '0;
          st_n   = ENG_SHIFT;
        end
      end
      ENG_SHIFT: begin
        if (expire) begin
          tmr_n = '0;
          sck_n = !sck_r;
          if (sample_e) rxb_n[pos] = miso;
          if (shift_e)  bi_n = bi + 1'b1;
          if (hc == HW'(2 * DW - 1)) st_n = ENG_TAIL;
          hc_n = hc + 1'b1;
        end else begin
          tmr_n = tmr + 1'b1;
        end
      end
      ENG_TAIL: begin
        if (expire) begin
          tmr_n     = '0;
          byte_done = 1'b1;
          rx_push   = rx_en;
          if (!cfg.use_eof || eof_r) ss_nx = 1'b1;
          st_n      = ENG_IDLE;
        end else begin
          tmr_n = tmr + 1'b1;
        end
      end
      default: st_n = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ENG_IDLE;
      tmr   <= '0;
      hc    <= '0;
      bi    <= '0;
      txb   <= '0;
      rxb   <= '0;
      eof_r <= 1'b0;
      sck_r <= 1'b0;
      ss_r  <= 1'b1;
    end else begin
      st    <= st_n;
      tmr   <= tmr_n;
      hc    <= hc_n;
      bi    <= bi_n;
      txb   <= txb_n;
      rxb   <= rxb_n;
      eof_r <= eof_n;
      sck_r <= sck_n;
      ss_r  <= ss_nx;
    end
  end

  assign busy    = (st != ENG_IDLE);
  assign sck     = busy ? sck_r : cfg.cpol;
  assign mosi    = ss_r ? 1'b0 : txb[pos];
  assign ss_n    = ss_r;
  assign rx_byte = rxb;
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        spi_miso,
  output logic        spi_sck,
  output logic        spi_mosi,
  output logic        spi_ss_n,
  output logic        irq
);
  spi_cfg_t        cfg;
  logic [DIVW-1:0] div;
  logic            tx_en, rx_en, tx_push, tx_flush, rx_flush, rx_pop;
  logic [DW:0]     tx_din, tx_head;
  logic [DW-1:0]   rx_head, rx_byte;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            tx_pop, rx_push, busy, byte_done, stat, stat_clr;
  logic            tx_valid, rx_full;

  assign tx_valid = (tx_cnt != '0);
  assign rx_full  = (rx_cnt == CW'(DEPTH));

  spi_fm_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .div(div),
    .tx_en(tx_en), .rx_en(rx_en), .tx_push(tx_push), .tx_din(tx_din),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .rx_pop(rx_pop),
    .rx_count(rx_cnt), .tx_count(tx_cnt), .rx_head(rx_head), .busy(busy),
    .stat(stat), .stat_clr(stat_clr), .irq(irq)
  );

  spi_fm_fifo #(.W(DW + 1), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .din(tx_din),
    .pop(tx_pop), .dout(tx_head), .count(tx_cnt)
  );

  spi_fm_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_head), .count(rx_cnt)
  );

  spi_fm_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .div(div), .tx_en(tx_en),
    .rx_en(rx_en), .tx_valid(tx_valid), .tx_byte(tx_head[DW-1:0]),
    .tx_eof(tx_head[DW]), .rx_full(rx_full), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .miso(spi_miso), .sck(spi_sck),
    .mosi(spi_mosi), .ss_n(spi_ss_n), .busy(busy), .byte_done(byte_done)
  );
endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker
  import spi_fm_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ss_n,
  input logic          sck,
  input spi_cfg_t      cfg,
  input logic          busy,
  input logic          byte_done,
  input logic          rx_en,
  input logic          rx_full,
  input logic [CW-1:0] rx_count,
  input logic          stat,
  input logic          stat_clr
);
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ss_n |-> (sck == cfg.cpol)); // R2
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_count <= CW'(DEPTH)); // R7
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n) (!busy && rx_en && rx_full) |=> !busy); // R8
  AST_SS_AT_BYTE_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(ss_n) |-> $past(byte_done)); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ($past(stat) && !$past(stat_clr)) |-> stat); // R9
endmodule

bind spi_frame_master spi_fm_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(spi_ss_n), .sck(spi_sck), .cfg(cfg),
  .busy(busy), .byte_done(byte_done), .rx_en(rx_en), .rx_full(rx_full),
  .rx_count(rx_cnt), .stat(stat), .stat_clr(stat_clr)
);

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic miso = 0, sck, mosi, ss_n, irq;

  spi_frame_master #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_miso(miso), .spi_sck(sck), .spi_mosi(mosi), .spi_ss_n(ss_n), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural slave and reference state
  bit cpol_b = 0, cpha_b = 0, lsb_b = 0;
  int div_b = 0;
  logic [7:0] cap_q[$], sv_q[$];
  logic [7:0] cap = 0, sv_cur = 8'h3C;
  int idx = 0, tg = 0, hp = 0, sb_n = 0, ss_rises = 0;
  logic p_sck = 0, p_ss = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ss_n) chk(sck == cpol_b, "R2", "idle sck level", sck, cpol_b);
      if (!ss_n && sck != p_sck) begin
        if (tg > 0) chk(hp == div_b + 1, "R4", "sck half period", hp, div_b + 1);
        hp = 0;
        tg++;
        if (tg == 16) tg = 0;
        if ((p_sck == cpol_b) != cpha_b) begin
          cap[lsb_b ? idx : 7 - idx] = mosi;
          idx++;
          if (idx == 8) begin
            cap_q.push_back(cap);
            sv_q.push_back(sv_cur);
            sv_cur = sv_cur * 8'd5 + 8'h11;
            sb_n++;
            idx = 0;
          end
        end
      end
      hp++;
      if (ss_n && !p_ss) ss_rises++;
      miso <= lsb_b ? sv_cur[idx] : sv_cur[7 - idx];
      p_sck = sck;
      p_ss = ss_n;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #2;
    reg_rd = 0;
  endtask

  task automatic set_cfg(input bit pol, input bit pha, input bit lsb, input bit eof);
    logic [31:0] v;
    v = 32'h0180C000 | (32'(lsb) << 28) | (32'(pol) << 13) | (32'(pha) << 12) | (32'(eof) << 11);
    wr(4'd0, v);
    cpol_b = pol; cpha_b = pha; lsb_b = lsb;
  endtask

  task automatic wait_bytes(input int n);
    while (sb_n < n) @(posedge clk);
    repeat (2 * (div_b + 1) + 4) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n0, r0;
    logic [7:0] b0, b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(ss_n == 1, "R1", "ss_n after reset", ss_n, 1);
    chk(sck == 0, "R1", "sck after reset", sck, 0);
    chk(irq == 0, "R1", "irq after reset", irq, 0);
    rd(4'd7, d); chk(d == 0, "R1", "rx count after reset", d, 0);
    rd(4'd9, d); chk(d == DEPTH / 4, "R10", "tx size", d, DEPTH / 4);
    rd(4'd10, d); chk(d == DEPTH / 4, "R10", "rx size", d, DEPTH / 4);

    wr(4'd1, 32'h5A010000); div_b = 1;
    rd(4'd1, d); chk(d == 32'h5A010000, "R4", "clock word readback", d, 32'h5A010000);
    wr(4'd2, 32'h14);

    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 2; l++) begin
        set_cfg(m[1], m[0], l[0], 1);
        b0 = 8'h96 + 8'(m * 29 + l * 7);
        b1 = ~b0 ^ 8'h21;
        n0 = sb_n; r0 = ss_rises;
        wr(4'd3, {24'd0, b0});
        wr(4'd4, 32'd1);
        wr(4'd3, {24'd0, b1});
        wait_bytes(n0 + 2);
        chk(cap_q[n0] == b0, l ? "R3" : "R2", "mosi byte 0", cap_q[n0], b0);
        chk(cap_q[n0 + 1] == b1, l ? "R3" : "R2", "mosi byte 1", cap_q[n0 + 1], b1);
        chk(ss_rises - r0 == 1, "R5", "select rises per frame", ss_rises - r0, 1);
        chk(ss_n == 1, "R5", "select released after eof byte", ss_n, 1);
        rd(4'd7, d); chk(d == 2, "R7", "rx count", d, 2);
        rd(4'd8, d); chk(d[7:0] == sv_q[n0], l ? "R3" : "R2", "miso byte 0", d, sv_q[n0]);
        rd(4'd8, d); chk(d[7:0] == sv_q[n0 + 1], l ? "R3" : "R2", "miso byte 1", d, sv_q[n0 + 1]);
        rd(4'd7, d); chk(d == 0, "R7", "rx count after pops", d, 0);
      end
    end

    // R6: frame mode off
    set_cfg(0, 0, 0, 0);
    n0 = sb_n; r0 = ss_rises;
    wr(4'd3, 32'h11); wr(4'd3, 32'h22);
    wait_bytes(n0 + 2);
    chk(ss_rises - r0 == 2, "R6", "select rises per byte", ss_rises - r0, 2);
    wr(4'd2, 32'h1);

    // R4: high divider byte
    wr(4'd1, 32'h00000100); div_b = 256;
    n0 = sb_n;
    wr(4'd3, 32'hC3);
    wait_bytes(n0 + 1);
    chk(cap_q[n0] == 8'hC3, "R4", "byte at divider 256", cap_q[n0], 8'hC3);
    wr(4'd1, 32'h00010000); div_b = 1;

    // R8: receive full stall
    wr(4'd2, 32'h1);
    n0 = sb_n;
    for (int i = 0; i < 4; i++) wr(4'd3, 32'h40 + i);
    wait_bytes(n0 + 4);
    rd(4'd7, d); chk(d == 4, "R8", "rx full count", d, 4);
    wr(4'd3, 32'h55);
    repeat (100) @(posedge clk);
    chk(sb_n == n0 + 4, "R8", "no byte while rx full", sb_n, n0 + 4);
    rd(4'd8, d); chk(d[7:0] == sv_q[n0], "R8", "oldest rx byte", d, sv_q[n0]);
    wait_bytes(n0 + 5);
    chk(cap_q[n0 + 4] == 8'h55, "R8", "resumed byte", cap_q[n0 + 4], 8'h55);
    rd(4'd7, d); chk(d == 4, "R8", "rx count after resume", d, 4);
    wr(4'd2, 32'h1);
    rd(4'd7, d); chk(d == 0, "R11", "rx flush", d, 0);

    // R9 status and mask
    wr(4'd6, 32'h1);
    @(negedge clk); chk(irq == 1, "R9", "irq when drained and masked in", irq, 1);
    wr(4'd2, 32'h8);
    n0 = sb_n;
    wr(4'd3, 32'h77);
    wr(4'd5, 32'h1);
    rd(4'd5, d); chk(d == 0, "R9", "status cleared by write one", d, 0);
    @(negedge clk); chk(irq == 0, "R9", "irq after clear", irq, 0);
    repeat (50) @(posedge clk);
    chk(sb_n == n0, "R11", "no byte while tx disabled", sb_n, n0);
    wr(4'd6, 32'h0);
    wr(4'd2, 32'h4);
    wait_bytes(n0 + 1);
    rd(4'd5, d); chk(d == 1, "R9", "status set after drain", d, 1);
    @(negedge clk); chk(irq == 0, "R9", "irq masked out", irq, 0);
    wr(4'd6, 32'h1);
    @(negedge clk); chk(irq == 1, "R9", "irq after unmask", irq, 1);

    // R11 tx flush
    wr(4'd2, 32'h9);
    n0 = sb_n;
    wr(4'd3, 32'h99);
    wr(4'd2, 32'h2);
    wr(4'd2, 32'h4);
    repeat (100) @(posedge clk);
    chk(sb_n == n0, "R11", "flushed tx byte not sent", sb_n, n0);

    // R7 receive disabled
    wr(4'd2, 32'h21);
    wr(4'd3, 32'h3A);
    wait_bytes(n0 + 1);
    rd(4'd7, d); chk(d == 0, "R7", "rx dropped while disabled", d, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule